// File: doc/BRIEF.md
# Two-Queue ADC Conversion Sequencer

This block drives an external analog-to-digital converter from a 64-entry table of conversion commands. Each entry holds a channel number and a pause bit. The table is split into two queues at a programmable boundary index. Queue 1 owns the entries below the boundary and queue 2 owns the entries from the boundary up to the last index. Each queue is started by its own trigger source: a software strobe, a rising edge on an external pin, or a shared interval timer. Queue 1 can also run in a gated mode, where it converts only while a level input is high. Queue 1 always has precedence. When it becomes runnable, queue 2 yields after the conversion in flight and later resumes at the entry where it stopped.

The converter is reached through a request/done handshake. The sequencer presents a channel number with a request. It stores the returned 10-bit sample in a result slot with the same index as the command that produced it. A pause bit splits a queue into sub-queues. Completion and pause events latch flags, and the flags raise an interrupt through per-flag enables. Software can read both queue pointers. Results can be read in three justifications, and the address region selects which one.

Top module: `adc_queue_seq`

## Requirements
- R1: After reset, `conv_req`, `flags` and `irq` are 0, `q1_ptr` is 0, `q2_ptr` equals `q2_base`, every result slot reads 0, and every command entry holds the end code 63.
- R2: Handshake and storage.
  - `conv_req` stays high with `conv_chan` unchanged until `conv_done` is seen.
  - `conv_req` is low in the cycle after `conv_done`.
  - The value on `conv_data` is stored in the result slot whose index equals the command's table index.
- R3: A command entry whose channel is 63 ends its queue when reached. It is never converted, and the entries after it in that queue are not converted.
- R4: In non-gated mode, an entry with its pause bit set halts the queue after it is converted. The pause flag is set and the pointer moves to the next entry. The next trigger resumes the queue there.
- R5: Queue 1 has priority. If queue 1 becomes runnable while queue 2 is running, queue 2 stops after its in-flight conversion. Queue 2 then resumes at its next unconverted entry once queue 1 completes or pauses, with no entry repeated or skipped.
- R6: Scan modes.
  - In single-scan mode (`qN_cont`=0), a queue stops on completion.
  - In continuous mode (`qN_cont`=1), it restarts at its first entry with no new trigger.
  - Setting the source to 0 stops a running queue after its in-flight conversion.
- R7: Trigger sources and ignored events.
  - `qN_src` 1 selects the software strobe `sw_goN`, 2 selects a rising edge of `ext_trigN`, and 3 selects the timer. A held level does not retrigger.
  - Events from a source that is not selected are ignored.
  - Triggers that arrive while the queue is running are ignored.
- R8: The interval timer emits one tick every `tmr_period` cycles, starting from reset. The tick is shared by both queues.
- R9: Gated mode (`q1_gated`=1, queue 1 only).
  - Queue 1 converts only while `gate1` is high. When `gate1` falls, it finishes the conversion in flight and holds its pointer.
  - In single-scan mode, after completing it waits for `gate1` to go low and then high again.
- R10: Flags and interrupt.
  - `flags` bits are: [0] queue 1 complete, [1] queue 1 pause, [2] queue 2 complete, [3] queue 2 pause.
  - A flag stays set until its `flag_clr` bit is pulsed. If a set and a clear fall in the same cycle, the set wins.
  - `irq` is high whenever any flag is set together with its `irq_en` bit.
- R11: `rd_addr[5:0]` selects a result slot r, and `rd_addr[7:6]` selects the format:
  - 0: right-justified unsigned {6'b0,r}
  - 1: left-justified signed {~r[9],r[8:0],6'b0}
  - 2: left-justified unsigned {r,6'b0}
  - 3: reads 0
- R12: Queue bounds and pointers.
  - Queue 1 spans indices 0 to `q2_base`-1 and is empty when `q2_base` is 0. Queue 2 spans `q2_base` to 63.
  - Each pointer shows the next index its queue will convert, and returns to the queue's first index on completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command table write strobe |
| cmd_addr | input | 6 | Command table write index |
| cmd_chan | input | 6 | Channel field written (63 = end of queue) |
| cmd_pause | input | 1 | Pause bit written |
| q2_base | input | 6 | First index of queue 2 |
| q1_src | input | 2 | Queue 1 trigger source (0 off, 1 software, 2 edge, 3 timer) |
| q2_src | input | 2 | Queue 2 trigger source |
| q1_cont | input | 1 | Queue 1 continuous scan |
| q2_cont | input | 1 | Queue 2 continuous scan |
| q1_gated | input | 1 | Queue 1 gated mode |
| gate1 | input | 1 | Queue 1 gate level |
| sw_go1 | input | 1 | Queue 1 software trigger strobe |
| sw_go2 | input | 1 | Queue 2 software trigger strobe |
| ext_trig1 | input | 1 | Queue 1 external trigger pin |
| ext_trig2 | input | 1 | Queue 2 external trigger pin |
| tmr_period | input | 16 | Interval timer period in cycles |
| irq_en | input | 4 | Interrupt enables, one per flag |
| flag_clr | input | 4 | Flag clear strobes |
| flags | output | 4 | Latched complete/pause flags |
| irq | output | 1 | Interrupt request |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 6 | Channel to convert |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 10 | Converted sample |
| q1_ptr | output | 6 | Next index of queue 1 |
| q2_ptr | output | 6 | Next index of queue 2 |
| rd_addr | input | 8 | Result read address (format region and slot) |
| rd_data | output | 16 | Formatted result |

## Verification
The assertions rely on the converter raising `conv_done` for exactly one cycle, and only while `conv_req` is high. They also rely on `q2_base`, the trigger sources and the mode bits changing only while no queue is partway through its entries. The bench's converter model waits a random 0 to 3 cycles under a live request and then pulses done once. Every test changes configuration only after reset, after a queue has completed, or when stopping a queue through its source. The gate-hold property only relies on the gate being low in a cycle with no request open, which the gated stimulus produces by lowering `gate1` at a conversion boundary.

// File: rtl/adc_queue_seq.sv
module adc_queue_seq #(
  parameter int IDX_W = 6,
  parameter int CH_W  = 6,
  parameter int RES_W = 10,
  parameter int RD_W  = 16,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [IDX_W-1:0] cmd_addr,
  input  logic [CH_W-1:0]  cmd_chan,
  input  logic             cmd_pause,
  input  logic [IDX_W-1:0] q2_base,
  input  logic [1:0]       q1_src,
  input  logic [1:0]       q2_src,
  input  logic             q1_cont,
  input  logic             q2_cont,
  input  logic             q1_gated,
  input  logic             gate1,
  input  logic             sw_go1,
  input  logic             sw_go2,
  input  logic             ext_trig1,
  input  logic             ext_trig2,
  input  logic [TMR_W-1:0] tmr_period,
  input  logic [3:0]       irq_en,
  input  logic [3:0]       flag_clr,
  output logic [3:0]       flags,
  output logic             irq,
  output logic             conv_req,
  output logic [CH_W-1:0]  conv_chan,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic [IDX_W-1:0] q1_ptr,
  output logic [IDX_W-1:0] q2_ptr,
  input  logic [IDX_W+1:0] rd_addr,
  output logic [RD_W-1:0]  rd_data
);
  localparam int N    = 1 << IDX_W;
  localparam int LPAD = RD_W - RES_W;
  localparam logic [CH_W-1:0] EOQ = {CH_W{1'b1}};

  logic [CH_W-1:0]  cmd_ch [N];
  logic [N-1:0]     cmd_p;
  logic [RES_W-1:0] res [N];

  logic [IDX_W-1:0] off1, off2, idx2, cur;
  logic             act1, act2, hold1, busy, own2;
  logic [CH_W-1:0]  chan_q;
  logic             trig_d1, trig_d2;
  logic [TMR_W-1:0] tmr_cnt;
  logic             tick;

  assign idx2   = q2_base + off2;
  assign q1_ptr = off1;
  assign q2_ptr = idx2;

  assign tick = ({1'b0, tmr_cnt} + (TMR_W+1)'(1)) >= {1'b0, tmr_period};

  logic ev1, ev2, run1, run2, sel2, pend, pick, issue, fin, fin1, fin2;
  logic last1, last2, empty1, p_cur;
  logic cpl1, cpl2, pf1, pf2;
  logic [IDX_W-1:0] pidx;

  assign ev1 = (q1_src == 2'd1 && sw_go1) || (q1_src == 2'd2 && ext_trig1 && !trig_d1) ||
               (q1_src == 2'd3 && tick);
  assign ev2 = (q2_src == 2'd1 && sw_go2) || (q2_src == 2'd2 && ext_trig2 && !trig_d2) ||
               (q2_src == 2'd3 && tick);

  assign run1 = q1_gated ? (gate1 && !hold1) : (act1 && q1_src != 2'd0);
  assign run2 = act2 && q2_src != 2'd0;

  assign empty1 = (q2_base == '0);
  assign last1  = (off1 == q2_base - IDX_W'(1));
  assign last2  = &idx2;

  assign sel2 = !run1 && run2;
  assign pidx = sel2 ? idx2 : off1;
  assign pend = sel2 ? (cmd_ch[idx2] == EOQ) : (empty1 || cmd_ch[off1] == EOQ);
  assign pick = !busy && (run1 || run2);
  assign issue = pick && !pend;

  assign fin   = busy && conv_done;
  assign fin1  = fin && !own2;
  assign fin2  = fin && own2;
  assign p_cur = cmd_p[cur];

  assign cpl1 = (pick && !sel2 && pend) || (fin1 && last1);
  assign cpl2 = (pick && sel2 && pend) || (fin2 && last2);
  assign pf1  = fin1 && !last1 && p_cur;
  assign pf2  = fin2 && !last2 && p_cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        cmd_ch[i] <= EOQ;
        res[i]    <= '0;
      end
      cmd_p <= '0;
    end else begin
      if (cmd_we) begin
        cmd_ch[cmd_addr] <= cmd_chan;
        cmd_p[cmd_addr]  <= cmd_pause;
      end
      if (fin) res[cur] <= conv_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off1 <= '0; off2 <= '0;
      act1 <= 1'b0; act2 <= 1'b0; hold1 <= 1'b0;
      busy <= 1'b0; own2 <= 1'b0; cur <= '0; chan_q <= '0;
      trig_d1 <= 1'b0; trig_d2 <= 1'b0;
      tmr_cnt <= '0;
      flags <= '0;
    end else begin
      trig_d1 <= ext_trig1;
      trig_d2 <= ext_trig2;
      tmr_cnt <= tick ? '0 : tmr_cnt + TMR_W'(1);

      if (cpl1) off1 <= '0;
      else if (fin1) off1 <= off1 + IDX_W'(1);
      if (cpl2) off2 <= '0;
      else if (fin2) off2 <= off2 + IDX_W'(1);

      if (q1_src == 2'd0 || q1_gated) act1 <= 1'b0;
      else if (cpl1) act1 <= q1_cont;
      else if (pf1) act1 <= 1'b0;
      else if (ev1) act1 <= 1'b1;

      if (q2_src == 2'd0) act2 <= 1'b0;
      else if (cpl2) act2 <= q2_cont;
      else if (pf2) act2 <= 1'b0;
      else if (ev2) act2 <= 1'b1;

      if (!q1_gated || !gate1) hold1 <= 1'b0;
      else if (cpl1 && !q1_cont) hold1 <= 1'b1;

      if (issue) begin
        busy   <= 1'b1;
        own2   <= sel2;
        cur    <= pidx;
        chan_q <= cmd_ch[pidx];
      end else if (fin) begin
        busy <= 1'b0;
      end

      flags <= (flags & ~flag_clr) | {pf2, cpl2, pf1, cpl1};
    end
  end

  assign conv_req  = busy;
  assign conv_chan = chan_q;
  assign irq       = |(flags & irq_en);

  logic [RES_W-1:0] rsel;
  assign rsel = res[rd_addr[IDX_W-1:0]];

  always_comb begin
    case (rd_addr[IDX_W+1:IDX_W])
      2'd0:    rd_data = {{LPAD{1'b0}}, rsel};
      2'd1:    rd_data = {~rsel[RES_W-1], rsel[RES_W-2:0], {LPAD{1'b0}}};
      2'd2:    rd_data = {rsel, {LPAD{1'b0}}};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/adc_queue_seq_chk.sv
module adc_queue_seq_chk #(
  parameter int IDX_W = 6,
  parameter int CH_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_req,
  input logic             conv_done,
  input logic [CH_W-1:0]  conv_chan,
  input logic             q1_gated,
  input logic             gate1,
  input logic [IDX_W-1:0] q1_ptr,
  input logic [3:0]       irq_en,
  input logic             irq
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done) |=> (conv_req && $stable(conv_chan)));

  // R2
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && conv_done) |=> !conv_req);

  // R3
  eoq_never_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (conv_chan != {CH_W{1'b1}}));

  // R9
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q1_gated && !gate1 && !conv_req) |=> $stable(q1_ptr));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 4'd0) |-> !irq);
endmodule

bind adc_queue_seq adc_queue_seq_chk #(.IDX_W(IDX_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .conv_done(conv_done),
  .conv_chan(conv_chan), .q1_gated(q1_gated), .gate1(gate1), .q1_ptr(q1_ptr),
  .irq_en(irq_en), .irq(irq)
);

// File: tb/adc_queue_seq_test.sv
module adc_queue_seq_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cmd_we, cmd_pause, q1_cont, q2_cont, q1_gated, gate1;
  logic sw_go1, sw_go2, ext_trig1, ext_trig2, conv_done, irq, conv_req;
  logic [5:0] cmd_addr, cmd_chan, q2_base, conv_chan, q1_ptr, q2_ptr;
  logic [1:0] q1_src, q2_src;
  logic [15:0] tmr_period, rd_data;
  logic [3:0] irq_en, flag_clr, flags;
  logic [9:0] conv_data;
  logic [7:0] rd_addr;

  adc_queue_seq uut (.*);

  int nchk = 0, nbad = 0;
  int log_n = 0;
  logic [5:0] log_ch [512];
  int wcnt = 0, lat = 1;
  bit ended = 0;

  function automatic logic [9:0] cv(input logic [5:0] ch);
    int t;
    t = int'(ch) * 37 + 5;
    return t[9:0];
  endfunction

  always @(negedge clk) begin
    if (conv_done) conv_done <= 1'b0;
    else if (conv_req) begin
      if (wcnt >= lat) begin
        conv_done <= 1'b1;
        conv_data <= cv(conv_chan);
        if (log_n < 512) log_ch[log_n] = conv_chan;
        log_n++;
        wcnt = 0;
        lat = int'($urandom % 4);
      end else wcnt++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd(input int addr, output int v);
    rd_addr = addr[7:0];
    #1;
    v = int'(rd_data);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset();
    @(negedge clk);
    rst_n = 0; cmd_we = 0; cmd_pause = 0; cmd_addr = 0; cmd_chan = 0;
    q2_base = 6'd32; q1_src = 0; q2_src = 0; q1_cont = 0; q2_cont = 0;
    q1_gated = 0; gate1 = 0; sw_go1 = 0; sw_go2 = 0; ext_trig1 = 0; ext_trig2 = 0;
    tmr_period = 16'd200; irq_en = 0; flag_clr = 0; conv_done = 0; conv_data = 0;
    rd_addr = 0;
    cyc(3);
    rst_n = 1;
    log_n = 0;
    cyc(1);
  endtask

  task automatic wr(input int idx, input int ch, input bit p);
    cmd_we = 1; cmd_addr = idx[5:0]; cmd_chan = ch[5:0]; cmd_pause = p;
    cyc(1);
    cmd_we = 0;
  endtask

  task automatic go1(); sw_go1 = 1; cyc(1); sw_go1 = 0; endtask
  task automatic go2(); sw_go2 = 1; cyc(1); sw_go2 = 0; endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 8) begin
      cyc(1);
      if (conv_req) q = 0; else q++;
    end
  endtask

  task automatic wait_log(input int n);
    int g = 0;
    while (log_n < n && g < 2000) begin cyc(1); g++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      nchk++; nbad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int v, pos;
    int tbl [64];
    void'($urandom(32'd1234));
    rst_n = 0;
    reset();

    // R1 reset state
    chk("R1 conv_req", int'(conv_req), 0);
    chk("R1 flags", int'(flags), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 q1_ptr", int'(q1_ptr), 0);
    chk("R1 q2_ptr", int'(q2_ptr), 32);
    rd(7, v); chk("R1 result zero", v, 0);

    // R2 R12 queue 1 ends at boundary; R10 flags
    q2_base = 4;
    wr(0, 3, 0); wr(1, 9, 0); wr(2, 17, 0); wr(3, 20, 0); wr(4, 30, 0);
    q1_src = 1; go1(); wait_idle();
    chk("R12 q1 stops at base-1", log_n, 4);
    rd(0, v); chk("R2 slot0", v, int'(cv(3)));
    rd(3, v); chk("R2 slot3", v, int'(cv(20)));
    rd(4, v); chk("R12 slot4 untouched", v, 0);
    chk("R12 q1_ptr back to 0", int'(q1_ptr), 0);
    chk("R10 q1 complete flag", int'(flags), 1);
    chk("R10 irq masked", int'(irq), 0);
    irq_en = 4'b0001; #1;
    chk("R10 irq enabled", int'(irq), 1);
    flag_clr = 4'b0001; cyc(1); flag_clr = 0; #1;
    chk("R10 flag cleared", int'(flags), 0);
    chk("R10 irq after clear", int'(irq), 0);
    // R11 formats
    rd(8'h41, v); chk("R11 left signed", v, int'({~cv(9)[9], cv(9)[8:0], 6'b0}));
    rd(8'h81, v); chk("R11 left unsigned", v, int'({cv(9), 6'b0}));
    rd(8'hC1, v); chk("R11 region 3", v, 0);
    rd(8'h01, v); chk("R11 right unsigned", v, int'(cv(9)));

    // R3 end code
    reset(); q2_base = 10;
    wr(0, 4, 0); wr(1, 5, 0); wr(2, 63, 0); wr(3, 6, 0);
    q1_src = 1; go1(); wait_idle();
    chk("R3 conversions before end code", log_n, 2);
    rd(3, v); chk("R3 entry after end code", v, 0);
    chk("R3 complete flag", int'(flags[0]), 1);

    // R4 pause
    reset(); q2_base = 3;
    wr(0, 7, 1); wr(1, 8, 0); wr(2, 11, 0);
    q1_src = 1; go1(); wait_idle();
    chk("R4 halted after pause entry", log_n, 1);
    chk("R4 pause flag", int'(flags), 2);
    chk("R4 pointer at next", int'(q1_ptr), 1);
    flag_clr = 4'hF; cyc(1); flag_clr = 0;
    go1(); wait_idle();
    chk("R4 resumed", log_n, 3);
    chk("R4 resumed entry", int'(log_ch[1]), 8);
    chk("R4 complete after resume", int'(flags), 1);

    // R5 priority
    reset(); q2_base = 2;
    wr(0, 1, 0); wr(1, 2, 0);
    for (int i = 0; i < 5; i++) wr(2 + i, 10 + i, 0);
    q1_src = 1; q2_src = 1;
    go2(); wait_log(2); go1(); wait_idle();
    chk("R5 total conversions", log_n, 7);
    pos = -1;
    for (int i = 0; i < 7; i++) if (log_ch[i] == 6'd1 && pos < 0) pos = i;
    chk("R5 preempt point", int'(pos >= 2 && pos <= 3), 1);
    if (pos >= 0 && pos < 6) chk("R5 q1 entries adjacent", int'(log_ch[pos+1]), 2);
    begin
      int k = 10;
      for (int i = 0; i < 7; i++)
        if (i != pos && i != pos + 1) begin
          chk("R5 q2 resume order", int'(log_ch[i]), k);
          k++;
        end
    end
    chk("R5 both complete", int'(flags), 5);

    // R6 continuous
    reset(); q2_base = 2;
    wr(0, 5, 0); wr(1, 6, 0);
    q1_src = 1; q1_cont = 1; go1(); wait_log(6);
    for (int i = 0; i < 6; i++) chk("R6 continuous restart", int'(log_ch[i]), (i % 2) ? 6 : 5);
    q1_src = 0; wait_idle();
    v = log_n; cyc(20);
    chk("R6 source off stops", log_n, v);

    // R7 edge trigger, held level, ignored strobe
    reset(); q2_base = 2;
    wr(0, 21, 0); wr(1, 22, 0);
    q1_src = 2; ext_trig1 = 1; cyc(100);
    chk("R7 one pass per edge", log_n, 2);
    ext_trig1 = 0; cyc(5); go1(); cyc(30);
    chk("R7 software strobe ignored", log_n, 2);
    ext_trig1 = 1; wait_idle();
    chk("R7 second edge", log_n, 4);

    // R8 timer on queue 2, R12 queue 2 bounds
    reset(); q2_base = 60;
    wr(60, 33, 0); wr(61, 34, 0);
    q2_src = 3; tmr_period = 200;
    wait_log(2); cyc(150);
    chk("R8 no pass before next tick", log_n, 2);
    cyc(100);
    chk("R8 pass on next tick", log_n, 4);
    q2_src = 0; wait_idle();
    chk("R12 q2_ptr back to base", int'(q2_ptr), 60);

    reset(); q2_base = 61;
    wr(61, 40, 0); wr(62, 41, 0); wr(63, 42, 0);
    q2_src = 1; go2(); wait_idle();
    chk("R12 q2 runs to 63", log_n, 3);
    rd(63, v); chk("R12 slot63", v, int'(cv(42)));
    chk("R10 q2 complete flag", int'(flags), 4);

    // R9 gated
    reset(); q2_base = 8;
    for (int i = 0; i < 8; i++) wr(i, 50 + i, 0);
    q1_gated = 1; gate1 = 1;
    wait_log(3); gate1 = 0; cyc(30);
    chk("R9 gate low stops", log_n, 3);
    chk("R9 pointer held", int'(q1_ptr), 3);
    gate1 = 1; cyc(80);
    chk("R9 finishes while gated", log_n, 8);
    chk("R9 pointer wraps", int'(q1_ptr), 0);
    cyc(40);
    chk("R9 single scan waits for gate cycle", log_n, 8);
    gate1 = 0; cyc(2); gate1 = 1; wait_log(16); cyc(10); gate1 = 0; wait_idle();
    chk("R9 new gate restarts", log_n, 16);

    // R2 R3 R12 random tables
    for (int it = 0; it < 20; it++) begin
      int e1, e2, b;
      reset();
      b = 1 + int'($urandom % 63);
      q2_base = b[5:0];
      for (int i = 0; i < 64; i++) begin
        tbl[i] = ($urandom % 8 == 0) ? 63 : int'($urandom % 63);
        wr(i, tbl[i], 0);
      end
      e1 = 0;
      while (e1 < b && tbl[e1] != 63) e1++;
      e2 = b;
      while (e2 < 64 && tbl[e2] != 63) e2++;
      q1_src = 1; q2_src = 1;
      go1(); wait_idle();
      chk("R12 rand q1 count", log_n, e1);
      go2(); wait_idle();
      chk("R3 rand total count", log_n, e1 + (e2 - b));
      chk("R10 rand flags", int'(flags), 5);
      for (int i = 0; i < 64; i++) begin
        rd(i, v);
        chk("R2 rand slot", v, ((i < e1) || (i >= b && i < e2)) ? int'(cv(tbl[i][5:0])) : 0);
      end
    end

    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule